// File: doc/BRIEF.md
# Butterfly All-Reduce Summation Unit

This block adds up a vector of integer operands, one per lane, so that every lane ends up holding the complete total. There is no single root output. All lanes are captured together on a start pulse. The block then runs a fixed number of exchange rounds, one per clock. In each round, every lane adds its partner's running total to its own. The partner is found by flipping one bit of the lane index. That bit starts at the most significant position and moves one place lower each round.

The lane registers drive the output bus directly. Partial results are therefore visible while the block is working. Once it finishes, the totals stay on the bus until the next accepted start. A one-cycle completion pulse marks the moment the totals become final. Lane count and operand width are parameters. Sums wrap modulo 2^WIDTH.

Top module: `butterfly_allreduce`

## Requirements
- R1: A synchronous active-high reset clears every lane output to zero and drives busy and done low. This holds even when a reduction is in progress.
- R2: A start pulse sampled while busy is low loads each lane k from bits [k*WIDTH +: WIDTH] of the operand bus and raises busy on the same edge.
- R3: A start pulse sampled while busy is high is ignored: the lanes are not reloaded, and completion timing is unchanged.
- R4: Each round takes exactly one clock. Busy stays high for exactly log2(LANES) cycles after the load edge.
- R5: In round s, counting from 0, lane i combines with lane i XOR d, where d = LANES >> (s+1). After round s, lane i therefore holds the sum of all inputs j with j mod d == i mod d.
- R6: Every round reads only the values held before that round. As a result, the sum over all lanes exactly doubles, modulo 2^WIDTH, in each round.
- R7: On completion, every lane holds the same value: the sum of all LANES inputs, modulo 2^WIDTH.
- R8: Done is high for exactly one cycle. It rises on the edge where the final round commits, and busy falls on that same edge.
- R9: While idle, the lane outputs hold their values until the next accepted start, whatever the operand bus does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load operands and begin a reduction |
| opIn | input | LANES*WIDTH | Operand vector, lane k in bits [k*WIDTH +: WIDTH] |
| busy | output | 1 | High while exchange rounds are running |
| done | output | 1 | One-cycle pulse when the totals are final |
| sumOut | output | LANES*WIDTH | Per-lane running totals, same packing as opIn |

## Verification
Each lane is exposed on the output bus every cycle, so a wrong partner choice or a stale read cannot hide. It shows up on the very next edge, because that lane's value no longer matches its residue-class sum for that round. A stage counter that is off by one shows up in the same cycle: the completion pulse arrives early or late, or the round distances are applied in the wrong order. Either way, the intermediate sums go wrong before the final total does. One-hot sweeps across every lane check every route through the exchange on its own. Saturated operand vectors check that the sums wrap correctly.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  // Strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic load;  // capture operand bus into the lanes
    logic step;  // commit one exchange round
  } bflyCtrl_t;
endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  output bflyCtrl_t                           ctrl,
  output logic [$clog2($clog2(LANES)+1)-1:0]  stageIdx,
  output logic                                busy,
  output logic                                done
);
  localparam int STAGES = $clog2(LANES);
  localparam int SW     = $clog2(STAGES + 1);

  logic lastStage;
  assign lastStage = (stageIdx == SW'(STAGES - 1));

  assign ctrl.load = start && !busy;
  assign ctrl.step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      stageIdx <= '0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        busy     <= 1'b1;
        stageIdx <= '0;
      end else if (busy) begin
        if (lastStage) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          stageIdx <= '0;
        end else begin
          stageIdx <= stageIdx + 1'b1;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R3
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !lastStage) |=> (busy && stageIdx == $past(stageIdx) + 1'b1));
  // R4
  round_zero_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (stageIdx == '0));
  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && lastStage) |=> done);
endmodule

// File: rtl/bfly_lanes.sv
module bfly_lanes
  import bfly_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  bflyCtrl_t                           ctrl,
  input  logic [$clog2($clog2(LANES)+1)-1:0]  stageIdx,
  input  logic [LANES*WIDTH-1:0]              opIn,
  output logic [LANES*WIDTH-1:0]              laneFlat
);
  localparam int LW = $clog2(LANES);

  logic [WIDTH-1:0] laneReg  [LANES];
  logic [WIDTH-1:0] nextVal  [LANES];
  logic [LW-1:0]    partnerIdx [LANES];
  logic [LW-1:0]    distVal;
  logic [WIDTH-1:0] laneTotal;

  // distance halves each round, starting at LANES/2
  assign distVal = LW'(LANES >> (int'(stageIdx) + 1));

  // all sums formed from pre-round values; registers updated together below
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign partnerIdx[i] = LW'(i) ^ distVal;
    assign nextVal[i]    = laneReg[i] + laneReg[partnerIdx[i]];
    assign laneFlat[i*WIDTH +: WIDTH] = laneReg[i];

    always_ff @(posedge clk) begin
      if (rst)            laneReg[i] <= '0;
      else if (ctrl.load) laneReg[i] <= opIn[i*WIDTH +: WIDTH];
      else if (ctrl.step) laneReg[i] <= nextVal[i];
    end
  end

  always_comb begin
    laneTotal = '0;
    for (int k = 0; k < LANES; k++) laneTotal = laneTotal + laneReg[k];
  end

  // R6
  sum_doubles_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.step |=> (laneTotal == WIDTH'({$past(laneTotal), 1'b0})));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.step) |=> $stable(laneFlat));
endmodule

// File: rtl/butterfly_allreduce.sv
module butterfly_allreduce
  import bfly_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [LANES*WIDTH-1:0] opIn,
  output logic                   busy,
  output logic                   done,
  output logic [LANES*WIDTH-1:0] sumOut
);
  localparam int SW = $clog2($clog2(LANES) + 1);

  bflyCtrl_t     ctrl;
  logic [SW-1:0] stageIdx;

  bfly_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl),
    .stageIdx(stageIdx), .busy(busy), .done(done)
  );

  bfly_lanes #(.LANES(LANES), .WIDTH(WIDTH)) u_lanes (
    .clk(clk), .rst(rst), .ctrl(ctrl), .stageIdx(stageIdx),
    .opIn(opIn), .laneFlat(sumOut)
  );

  logic [LANES-1:0] sameVec;
  for (genvar i = 0; i < LANES; i++) begin : g_same
    assign sameVec[i] = (sumOut[i*WIDTH +: WIDTH] == sumOut[WIDTH-1:0]);
  end

  // R7
  lanes_agree_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (&sameVec));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && sumOut == '0));
endmodule

// File: tb/butterfly_allreduce_tb.sv
`timescale 1ns/1ps
module butterfly_allreduce_tb;
  localparam int LANES  = 8;
  localparam int WIDTH  = 16;
  localparam int STAGES = $clog2(LANES);

  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic [LANES*WIDTH-1:0] opIn = '0;
  logic busy, done;
  logic [LANES*WIDTH-1:0] sumOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  butterfly_allreduce #(.LANES(LANES), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .start(start), .opIn(opIn),
    .busy(busy), .done(done), .sumOut(sumOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected value of lane i after round s: sum of inputs j with j mod d == i mod d
  function automatic logic [WIDTH-1:0] classSum(input logic [LANES*WIDTH-1:0] v,
                                                input int i, input int d);
    logic [WIDTH-1:0] acc = '0;
    for (int j = 0; j < LANES; j++)
      if ((j % d) == (i % d)) acc = acc + v[j*WIDTH +: WIDTH];
    return acc;
  endfunction

  task automatic checkLanes(input logic [LANES*WIDTH-1:0] v, input int d,
                            input string req);
    for (int i = 0; i < LANES; i++) begin
      logic [WIDTH-1:0] e;
      e = classSum(v, i, d);
      check(sumOut[i*WIDTH +: WIDTH] == e, req, $sformatf("lane %0d d=%0d", i, d),
            sumOut[i*WIDTH +: WIDTH], e);
    end
  endtask

  task automatic runVector(input logic [LANES*WIDTH-1:0] v, input bit inject);
    @(negedge clk);
    opIn = v; start = 1;
    @(negedge clk);
    start = 0;
    // R2: loaded, busy high (d = LANES means identity class)
    check(busy == 1'b1, "R2", "busy after load", busy, 1);
    checkLanes(v, LANES, "R2");
    for (int s = 0; s < STAGES; s++) begin
      if (inject && s == 0) begin
        start = 1; opIn = ~v;  // R3: must be ignored
      end
      @(negedge clk);
      start = 0;
      checkLanes(v, LANES >> (s + 1), (s == STAGES - 1) ? "R7" : "R5");
      if (s == STAGES - 1) begin
        check(done == 1'b1 && busy == 1'b0, "R8", "done/busy at end",
              {done, busy}, 2'b10);
      end else begin
        check(busy == 1'b1 && done == 1'b0, "R4", "still busy mid-run",
              {done, busy}, 2'b01);
      end
    end
    opIn = ~v;
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    @(negedge clk);
    @(negedge clk);
    checkLanes(v, 1, "R9");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [LANES*WIDTH-1:0] v;
    logic [31:0] seed;
    opIn = '1; start = 1;
    repeat (3) @(negedge clk);
    start = 0;
    rst = 0;
    @(negedge clk);
    // R1
    check(sumOut == '0 && !busy && !done, "R1", "reset state", sumOut[31:0], 0);

    // all zero, all ones, small ones
    runVector('0, 0);
    runVector('1, 0);
    for (int i = 0; i < LANES; i++) v[i*WIDTH +: WIDTH] = 16'h0001;
    runVector(v, 0);
    for (int i = 0; i < LANES; i++) v[i*WIDTH +: WIDTH] = 16'h7FFF;
    runVector(v, 0);
    // one-hot sweep: every route through the exchange
    for (int k = 0; k < LANES; k++) begin
      v = '0;
      v[k*WIDTH +: WIDTH] = WIDTH'(k * 257 + 3);
      runVector(v, 0);
    end
    // distinct per-lane values
    for (int i = 0; i < LANES; i++) v[i*WIDTH +: WIDTH] = WIDTH'(1 << i);
    runVector(v, 0);
    // pseudo-random sweep, some with a start while busy (R3)
    seed = 32'hACE1_1234;
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < LANES; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        v[i*WIDTH +: WIDTH] = seed[31:16];
      end
      runVector(v, n[0]);
    end

    // R1: reset in mid-run
    @(negedge clk);
    opIn = '1; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(sumOut == '0 && !busy && !done, "R1", "mid-run reset",
          {busy, done}, 0);
    @(negedge clk);
    check(sumOut == '0 && !done, "R1", "quiet after reset", sumOut[31:0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule